// File: doc/BRIEF.md
# Round-Robin Event Time Multiplexer

This block gathers bunch-crossing–aligned packets from N input channels and steers each complete event to one of M output channels. An event is WPK words from every input for one bunch crossing. The inputs are read two at a time. The two words from a pair are joined into one double-width beat, and the pairs follow each other on the chosen output. Successive events rotate across the outputs in round-robin order, so each downstream processor receives whole events and has M bunch crossings of time to work on each one.

Each input is a first-word-fall-through FIFO read port. While `empty` is low, the head word is presented on the data bus, and a read strobe pops it at the clock edge. Each output is a valid/ready stream with data and a last marker, and it has a small queue in front of it. Outputs are grouped in bundles that share one valid. A beat moves only when valid is high and every member of the bundle has ready high in the same cycle. While a bundle is not ready, its head data holds still.

Back-pressure never reaches the inputs. If a queue is full, the arriving beat is dropped and that output raises a sticky overflow flag. After reset, the block waits until every input holds data before it starts the first event (the build-up phase). A status counter and pointer expose which output the next event will use.

Top module: `emux_top`

## Requirements
- R1: A beat reads input pair p (inputs 2p and 2p+1) in the same cycle, and only while both are non-empty. The beat data is {word of input 2p+1, word of input 2p}, with the odd input in the upper half.
- R2: Within an event, pair 0 goes first and then the pairs ascend. Each pair sends its WPK words in FIFO order. `out_tlast` is high only on the final beat of the event, which is the last word of the last pair.
- R3: The event numbered n after reset is delivered on output n mod M. `evt_bcid` counts completed events modulo 2^BW. `evt_out` names the output for the next event and wraps from M-1 to 0.
- R4: After reset no input is read until all N inputs are non-empty at once. `buildup` stays high until that first event starts.
- R5: Outputs g*BUNDLE to g*BUNDLE+BUNDLE-1 share one valid. It is high only when every member's queue holds a beat. A transfer pops all members, and it happens only when every member's ready is high.
- R6: While a bundle is valid and not fully ready, its valid and data hold. The multiplexer never stalls on output back-pressure. A beat that arrives at a full queue (DEPTH beats) is lost and sets that output's `out_ovf`, which stays set until reset.
- R7: After reset, `evt_bcid`=0, `evt_out`=0, `buildup`=1, and all of `out_tvalid`, `out_ovf` and `in_rd` are 0.

Ports of `emux_top`:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_empty | input | N_IN | Per-input FIFO empty |
| in_rd | output | N_IN | Per-input FIFO read strobe |
| in_data | input | N_IN*CW/2 | Per-input FIFO head words, input i at bits i*CW/2 |
| out_tvalid | output | M_OUT | Per-output valid (common within a bundle) |
| out_tready | input | M_OUT | Per-output ready |
| out_tdata | output | M_OUT*CW | Per-output combined beat |
| out_tlast | output | M_OUT | Last beat of an event |
| out_ovf | output | M_OUT | Sticky per-output overflow |
| buildup | output | 1 | High from reset until the first event starts |
| evt_bcid | output | BW | Completed event count |
| evt_out | output | clog2(M_OUT) | Output that the next event will use |

## Verification
Two things can land on one output queue in the same cycle: the multiplexer writes a new beat, and the bundle pops the head. Both rotation order and count bookkeeping depend on handling that collision correctly. The bench provokes it by streaming events back to back while ready toggles from a pseudo-random bit. A scoreboard then checks every beat, in order, against the data and last marker predicted from the event number. A second collision is a write into a full queue while ready is held low. That case is judged by overflow flags that rise while the event counter keeps advancing.

// File: rtl/emux_pkg.sv
package emux_pkg;
  typedef enum logic {SCH_IDLE, SCH_RUN} sch_state_e;

  function automatic int safe_clog2(input int v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction
endpackage

// File: rtl/emux_sched.sv
module emux_sched
  import emux_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int M_OUT = 4,
  parameter int IW    = 128,
  parameter int WPK   = 2,
  parameter int BW    = 12,
  localparam int MW   = safe_clog2(M_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_IN-1:0]    in_empty,
  output logic [N_IN-1:0]    in_rd,
  input  logic [N_IN*IW-1:0] in_data,
  output logic [M_OUT-1:0]   wr_en,
  output logic [2*IW-1:0]    wr_data,
  output logic               wr_last,
  output logic               buildup,
  output logic [BW-1:0]      evt_bcid,
  output logic [MW-1:0]      evt_out
);
  localparam int NP = N_IN / 2;
  localparam int PW = safe_clog2(NP);
  localparam int KW = safe_clog2(WPK);

  sch_state_e    state_q;
  logic [PW-1:0] pair_q;
  logic [KW-1:0] word_q;
  logic [MW-1:0] ptr_q;
  logic [BW-1:0] bcid_q;
  logic          boot_q;
  logic          pair_ready, beat, end_word, end_pair;

  always_comb begin
    pair_ready = 1'b0;
    wr_data    = '0;
    for (int p = 0; p < NP; p++) begin
      if (PW'(p) == pair_q) begin
        pair_ready = !in_empty[2*p] && !in_empty[2*p+1];
        wr_data    = in_data[2*p*IW +: 2*IW];
      end
    end
    beat = (state_q == SCH_RUN) && pair_ready;
    for (int i = 0; i < N_IN; i++) in_rd[i] = beat && (PW'(i/2) == pair_q);
    end_word = (word_q == KW'(WPK-1));
    end_pair = (pair_q == PW'(NP-1));
    wr_last  = end_word && end_pair;
    for (int j = 0; j < M_OUT; j++) wr_en[j] = beat && (ptr_q == MW'(j));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      pair_q  <= '0;
      word_q  <= '0;
      ptr_q   <= '0;
      bcid_q  <= '0;
      boot_q  <= 1'b1;
    end else begin
      case (state_q)
        SCH_IDLE: if (&(~in_empty)) begin
          state_q <= SCH_RUN;
          boot_q  <= 1'b0;
        end
        SCH_RUN: if (beat) begin
          if (!end_word) begin
            word_q <= word_q + 1'b1;
          end else begin
            word_q <= '0;
            if (!end_pair) begin
              pair_q <= pair_q + 1'b1;
            end else begin
              pair_q  <= '0;
              state_q <= SCH_IDLE;
              bcid_q  <= bcid_q + 1'b1;
              ptr_q   <= (ptr_q == MW'(M_OUT-1)) ? '0 : ptr_q + 1'b1;
            end
          end
        end
        default: state_q <= SCH_IDLE;
      endcase
    end
  end

  assign buildup  = boot_q;
  assign evt_bcid = bcid_q;
  assign evt_out  = ptr_q;
endmodule

// File: rtl/emux_outq.sv
module emux_outq #(
  parameter int DW    = 257,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          nempty,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          full, push, take;

  assign full   = (cnt == (AW+1)'(DEPTH));
  assign push   = wr_en && !full;
  assign take   = pop && (cnt != '0);
  assign head   = mem[rp];
  assign nempty = (cnt != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (take) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(take);
      if (wr_en && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/emux_bundle.sv
module emux_bundle #(
  parameter int B = 4
) (
  input  logic [B-1:0] nempty,
  input  logic [B-1:0] tready,
  output logic         gvalid,
  output logic [B-1:0] pop
);
  assign gvalid = &nempty;
  assign pop    = {B{gvalid && (&tready)}};
endmodule

// File: rtl/emux_top.sv
module emux_top
  import emux_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int M_OUT  = 4,
  parameter int CW     = 256,
  parameter int WPK    = 2,
  parameter int DEPTH  = 8,
  parameter int BUNDLE = 4,
  parameter int BW     = 12,
  localparam int IW    = CW / 2,
  localparam int MW    = safe_clog2(M_OUT),
  localparam int NG    = M_OUT / BUNDLE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_IN-1:0]     in_empty,
  output logic [N_IN-1:0]     in_rd,
  input  logic [N_IN*IW-1:0]  in_data,
  output logic [M_OUT-1:0]    out_tvalid,
  input  logic [M_OUT-1:0]    out_tready,
  output logic [M_OUT*CW-1:0] out_tdata,
  output logic [M_OUT-1:0]    out_tlast,
  output logic [M_OUT-1:0]    out_ovf,
  output logic                buildup,
  output logic [BW-1:0]       evt_bcid,
  output logic [MW-1:0]       evt_out
);
  logic [M_OUT-1:0] wr_en, q_nempty, q_pop;
  logic [CW-1:0]    wr_data;
  logic             wr_last;

  emux_sched #(.N_IN(N_IN), .M_OUT(M_OUT), .IW(IW), .WPK(WPK), .BW(BW)) u_sched (
    .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd), .in_data(in_data),
    .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .buildup(buildup),
    .evt_bcid(evt_bcid), .evt_out(evt_out)
  );

  for (genvar j = 0; j < M_OUT; j++) begin : g_q
    logic [CW:0] head;
    emux_outq #(.DW(CW+1), .DEPTH(DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en[j]), .wr_data({wr_last, wr_data}),
      .pop(q_pop[j]), .head(head), .nempty(q_nempty[j]), .ovf(out_ovf[j])
    );
    assign out_tlast[j]            = head[CW];
    assign out_tdata[j*CW +: CW]   = head[CW-1:0];
  end

  for (genvar g = 0; g < NG; g++) begin : g_b
    logic gv;
    emux_bundle #(.B(BUNDLE)) u_b (
      .nempty(q_nempty[g*BUNDLE +: BUNDLE]), .tready(out_tready[g*BUNDLE +: BUNDLE]),
      .gvalid(gv), .pop(q_pop[g*BUNDLE +: BUNDLE])
    );
    assign out_tvalid[g*BUNDLE +: BUNDLE] = {BUNDLE{gv}};
  end
endmodule

// File: rtl/emux_checks.sv
module emux_checks
  import emux_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int M_OUT  = 4,
  parameter int CW     = 256,
  parameter int BUNDLE = 4,
  localparam int MW    = safe_clog2(M_OUT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_IN-1:0]     in_empty,
  input logic [N_IN-1:0]     in_rd,
  input logic [M_OUT-1:0]    out_tvalid,
  input logic [M_OUT-1:0]    out_tready,
  input logic [M_OUT*CW-1:0] out_tdata,
  input logic [M_OUT-1:0]    out_ovf,
  input logic                buildup,
  input logic [MW-1:0]       evt_out
);
  logic pair_split;
  always_comb begin
    pair_split = 1'b0;
    for (int p = 0; p < N_IN/2; p++)
      if (in_rd[2*p] != in_rd[2*p+1]) pair_split = 1'b1;
  end

  p_pair_rd_r1: assert property (@(posedge clk) disable iff (!rst_n) !pair_split);
  p_rd_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n) (in_rd & in_empty) == '0);
  p_buildup_idle_r4: assert property (@(posedge clk) disable iff (!rst_n) buildup |-> in_rd == '0);
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n) evt_out <= MW'(M_OUT-1));

  for (genvar j = 0; j < M_OUT; j++) begin : g_chk
    localparam int BASE = (j / BUNDLE) * BUNDLE;
    p_grp_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_tvalid[j] == out_tvalid[BASE]);
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_tvalid[j] && !(&out_tready[BASE +: BUNDLE])) |=>
      (out_tvalid[j] && $stable(out_tdata[j*CW +: CW])));
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_ovf[j] |=> out_ovf[j]);
  end
endmodule

bind emux_top emux_checks #(.N_IN(N_IN), .M_OUT(M_OUT), .CW(CW), .BUNDLE(BUNDLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd), .out_tvalid(out_tvalid),
  .out_tready(out_tready), .out_tdata(out_tdata), .out_ovf(out_ovf), .buildup(buildup),
  .evt_out(evt_out)
);

// File: tb/emux_top_tb.sv
`timescale 1ns/1ps
module emux_top_tb;
  localparam int N = 4, M = 4, CW = 256, IW = 128, WPK = 2, BW = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N-1:0]      in_empty = '1;
  logic [N-1:0]      in_rd;
  logic [N*IW-1:0]   in_data = '0;
  logic [M-1:0]      out_tvalid, out_tready = '1, out_tlast, out_ovf;
  logic [M*CW-1:0]   out_tdata;
  logic              buildup;
  logic [BW-1:0]     evt_bcid;
  logic [1:0]        evt_out;

  logic [N-1:0]      rd_q = '0;
  logic [IW-1:0]     iq [N][$];
  logic [CW:0]       eq [M][$];
  int                mode = 0;
  logic [15:0]       lfsr = 16'hACE1;
  int                checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  emux_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .in_rd(in_rd), .in_data(in_data),
    .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tdata(out_tdata),
    .out_tlast(out_tlast), .out_ovf(out_ovf), .buildup(buildup),
    .evt_bcid(evt_bcid), .evt_out(evt_out)
  );

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [IW-1:0] word_of(input int ev, input int i, input int k);
    logic [31:0] t;
    t = {16'(ev), 8'(i), 8'(k)};
    return {4{t}};
  endfunction

  task automatic push_inputs(input int ev, input int lo, input int hi);
    for (int i = lo; i <= hi; i++)
      for (int k = 0; k < WPK; k++) iq[i].push_back(word_of(ev, i, k));
  endtask

  // Scoreboard driver side: R1/R2/R3 expectations
  task automatic push_expect(input int ev);
    int o;
    o = ev % M;
    for (int p = 0; p < N/2; p++)
      for (int k = 0; k < WPK; k++)
        eq[o].push_back({(p == N/2-1) && (k == WPK-1), word_of(ev, 2*p+1, k), word_of(ev, 2*p, k)});
  endtask

  task automatic push_event(input int ev);
    push_inputs(ev, 0, N-1);
    push_expect(ev);
  endtask

  always @(posedge clk) rd_q <= rst_n ? in_rd : '0;

  // ready drive, monitor, input FIFO model
  always @(negedge clk) begin
    case (mode)
      0: out_tready = '1;
      1: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_tready = {M{lfsr[0]}};
      end
      default: out_tready = '0;
    endcase
    if (rst_n && (&out_tready)) begin
      for (int j = 0; j < M; j++) begin
        if (out_tvalid[j]) begin
          if (eq[j].size() == 0) begin
            chk(1'b0, $sformatf("R3 out%0d unexpected beat act %h exp none", j, out_tdata[j*CW +: CW]));
          end else begin
            logic [CW:0] e, a;
            e = eq[j].pop_front();
            a = {out_tlast[j], out_tdata[j*CW +: CW]};
            chk(a == e, $sformatf("R1/R2 out%0d beat act %h exp %h", j, a, e));
          end
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      if (rd_q[i] && iq[i].size() > 0) void'(iq[i].pop_front());
      in_empty[i] = (iq[i].size() == 0);
      in_data[i*IW +: IW] = (iq[i].size() == 0) ? '0 : iq[i][0];
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) iq[i].delete();
    for (int j = 0; j < M; j++) eq[j].delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_drain(input int limit, input string tag);
    int n;
    bit busy;
    n = 0;
    busy = 1'b1;
    while (busy && n < limit) begin
      @(negedge clk);
      n++;
      busy = 1'b0;
      for (int i = 0; i < N; i++) if (iq[i].size() != 0) busy = 1'b1;
      for (int j = 0; j < M; j++) if (eq[j].size() != 0) busy = 1'b1;
    end
    chk(!busy, $sformatf("%s drain act busy=%0d exp 0", tag, busy));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R7 reset state
    chk(evt_bcid == 0 && evt_out == 0, $sformatf("R7 counters act %0d/%0d exp 0/0", evt_bcid, evt_out));
    chk(buildup == 1'b1, $sformatf("R7 buildup act %0b exp 1", buildup));
    chk(out_tvalid == '0 && out_ovf == '0 && in_rd == '0,
        $sformatf("R7 outputs act v%b o%b r%b exp 0", out_tvalid, out_ovf, in_rd));

    // R4: one input holding data is not enough
    push_inputs(0, 0, 0);
    repeat (8) @(negedge clk);
    chk(in_rd == '0 && buildup, $sformatf("R4 partial inputs act rd%b b%0b exp rd0 b1", in_rd, buildup));
    push_inputs(0, 1, N-1);
    push_expect(0);
    repeat (5) @(negedge clk);
    chk(!buildup, $sformatf("R4 buildup after start act %0b exp 0", buildup));

    // R3 rotation, R5 bundle wait
    for (int ev = 1; ev <= 4; ev++) push_event(ev);
    repeat (100) @(negedge clk);
    chk(evt_bcid == 5, $sformatf("R3 bcid act %0d exp 5", evt_bcid));
    chk(evt_out == 1, $sformatf("R3 next output act %0d exp 1", evt_out));
    chk(out_tvalid == '0, $sformatf("R5 lone member act %b exp 0000", out_tvalid));
    chk(eq[0].size() == 4, $sformatf("R5 held beats out0 act %0d exp 4", eq[0].size()));
    for (int ev = 5; ev <= 7; ev++) push_event(ev);
    wait_drain(2000, "R5");
    chk(evt_bcid == 8 && evt_out == 0, $sformatf("R3 wrap act %0d/%0d exp 8/0", evt_bcid, evt_out));

    // Random back-pressure: concurrent queue write and pop
    @(posedge clk);
    mode = 1;
    for (int ev = 8; ev < 40; ev++) push_event(ev);
    wait_drain(5000, "R6");
    chk(out_ovf == '0, $sformatf("R6 no loss act %b exp 0000", out_ovf));
    chk(evt_bcid == 40, $sformatf("R3 bcid act %0d exp 40", evt_bcid));

    // R6 overflow with ready held low
    @(posedge clk);
    mode = 2;
    for (int ev = 40; ev < 52; ev++) push_inputs(ev, 0, N-1);
    repeat (200) @(negedge clk);
    chk(out_ovf == '1, $sformatf("R6 overflow act %b exp 1111", out_ovf));
    chk(evt_bcid == 52, $sformatf("R6 mux not stalled act %0d exp 52", evt_bcid));
    chk(out_tvalid == '1, $sformatf("R5 full bundle act %b exp 1111", out_tvalid));

    @(posedge clk);
    mode = 0;
    do_reset();
    @(negedge clk);
    chk(out_ovf == '0 && evt_bcid == 0 && out_tvalid == '0,
        $sformatf("R7 re-reset act o%b c%0d v%b exp 0", out_ovf, evt_bcid, out_tvalid));
    finish_run();
  end
endmodule